// File: doc/BRIEF.md
# Wide-Register Load/Store Unit

This block carries out the integer memory operations of a core whose general registers are 128 bits wide. A decoded memory operation arrives with the low 64 bits of a base register, a 12-bit signed immediate, a destination register number and the full 128-bit store operand. The block forms a 64-bit byte address and drives a 64-bit memory port with a valid/ready handshake. Loads return a 128-bit register value through a single write-back pulse.

Byte, halfword, word and doubleword accesses take one memory beat. The byte lanes of that beat are chosen by the low three address bits, and loaded values are widened to 128 bits. Quadword accesses take two beats: the low half at the effective address, then the high half eight bytes above it. A quadword load writes its register once, after both beats. Operations that the current register-width mode does not allow are refused with a one-cycle flag and touch neither memory nor the register file.

Top module: `lsu128_unit`

## Requirements
- R1: The beat address is the 64-bit base plus the sign-extended 12-bit immediate, wrapping modulo 2^64.
- R2: Operation codes are LB=0, LH=1, LW=2, LD=3, LQ=4, LBU=5, LHU=6, LWU=7, LDU=8, SB=9, SH=10, SW=11, SD=12, SQ=13. A load of 1, 2, 4 or 8 bytes makes one beat with mem_we=0 and mem_be = ((1<<n)-1) << addr[2:0]. Its value is bytes addr .. addr+n-1 taken little-endian from that beat.
- R3: LB, LH, LW and LD fill every bit above the loaded value with its top bit, up to bit 127. LBU, LHU, LWU and LDU fill those bits with zero.
- R4: LQ makes two read beats, at ea and then ea+8, each with mem_be=8'hFF. wb_data is {second beat, first beat}.
- R5: SQ makes two write beats with mem_be=8'hFF: req_wdata[63:0] at ea, then req_wdata[127:64] at ea+8.
- R6: SB, SH, SW and SD make one write beat with mem_be = ((1<<n)-1) << addr[2:0]. Byte i of req_wdata is placed in lane addr[2:0]+i.
- R7: req_mode 2'b11 is 128-bit mode, 2'b10 is 64-bit mode, and any other value is 32-bit mode. LQ, SQ and LDU need 128-bit mode. LD, SD and LWU need 64-bit or 128-bit mode. Codes 14 and 15 are never legal. A refused operation raises illegal for one cycle, the cycle after it is accepted, and makes no beat and no write-back.
- R8: While a beat waits with mem_ready low, mem_addr, mem_we, mem_be and mem_wdata hold steady. req_ready stays low while a beat is pending.
- R9: A load raises wb_en for exactly one cycle, the cycle after its last read handshake. A load to register 0 still performs its beats but raises no wb_en.
- R10: During reset req_ready=1, mem_valid=0, wb_en=0 and illegal=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit idle, operation taken when valid |
| req_op | input | 4 | Operation code (R2) |
| req_mode | input | 2 | Register-width mode (R7) |
| req_base | input | ADDR_W | Low half of the base register |
| req_imm | input | IMM_W | Signed address offset |
| req_rd | input | RD_W | Destination register number |
| req_wdata | input | 128 | Store operand, both halves |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_we | output | 1 | Beat is a write |
| mem_be | output | 8 | Byte lane strobes |
| mem_wdata | output | 64 | Write data, lane aligned |
| mem_rdata | input | 64 | Read data of the handshaking beat |
| wb_en | output | 1 | Register write pulse |
| wb_rd | output | RD_W | Register written |
| wb_data | output | 128 | Value written |
| illegal | output | 1 | Operation refused in this mode |

## Verification
A held attribute that is corrupted shows up on the very beat it drives. A wrong size or offset gives the wrong strobes or lanes on mem_be or mem_wdata at the first handshake. A lost beat-sequencing state shows as a missing, repeated or misaddressed second quadword beat, or as req_ready rising early. A fault in the captured low half or in the widening logic only becomes visible on wb_data one cycle after the last read handshake. The reference model therefore compares every handshake and every write-back in the cycle it occurs, and counts beats and pulses per operation, so that extra or missing events are caught as well.

// File: rtl/lsu128_pkg.sv
package lsu128_pkg;

  localparam int BEAT_W     = 64;
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int LANE_W     = $clog2(BEAT_BYTES);
  localparam int REG_W      = 2 * BEAT_W;

  localparam logic [3:0] OP_LB  = 4'd0;
  localparam logic [3:0] OP_LH  = 4'd1;
  localparam logic [3:0] OP_LW  = 4'd2;
  localparam logic [3:0] OP_LD  = 4'd3;
  localparam logic [3:0] OP_LQ  = 4'd4;
  localparam logic [3:0] OP_LBU = 4'd5;
  localparam logic [3:0] OP_LHU = 4'd6;
  localparam logic [3:0] OP_LWU = 4'd7;
  localparam logic [3:0] OP_LDU = 4'd8;
  localparam logic [3:0] OP_SB  = 4'd9;
  localparam logic [3:0] OP_SH  = 4'd10;
  localparam logic [3:0] OP_SW  = 4'd11;
  localparam logic [3:0] OP_SD  = 4'd12;
  localparam logic [3:0] OP_SQ  = 4'd13;

  localparam logic [1:0] MODE_64  = 2'b10;
  localparam logic [1:0] MODE_128 = 2'b11;

  typedef enum logic [2:0] {SZ_B, SZ_H, SZ_W, SZ_D, SZ_Q} acc_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} beat_state_e;

  typedef struct packed {
    logic      legal;
    logic      store;
    logic      sext;
    acc_size_e size;
  } op_attr_t;

  // Strobes of a sub-quad access placed at a byte offset in the beat
  function automatic logic [BEAT_BYTES-1:0] lane_strobe(acc_size_e sz,
                                                        logic [LANE_W-1:0] off);
    logic [BEAT_BYTES-1:0] m;
    case (sz)
      SZ_B:    m = BEAT_BYTES'(1);
      SZ_H:    m = BEAT_BYTES'(3);
      SZ_W:    m = BEAT_BYTES'(15);
      default: m = '1;
    endcase
    return m << off;
  endfunction

  // Move store bytes up to their lanes
  function automatic logic [BEAT_W-1:0] lane_place(logic [BEAT_W-1:0] data,
                                                   logic [LANE_W-1:0] off);
    return data << {off, 3'b000};
  endfunction

  // Pick the loaded bytes out of the beat and widen them to a full register
  function automatic logic [REG_W-1:0] widen_load(logic [BEAT_W-1:0] rdata,
                                                  logic [LANE_W-1:0] off,
                                                  acc_size_e sz, logic sx);
    logic [BEAT_W-1:0] sh;
    logic [BEAT_W-1:0] lo;
    logic              fill;
    sh = rdata >> {off, 3'b000};
    case (sz)
      SZ_B: begin
        fill = sx & sh[7];
        lo   = {{(BEAT_W-8){fill}}, sh[7:0]};
      end
      SZ_H: begin
        fill = sx & sh[15];
        lo   = {{(BEAT_W-16){fill}}, sh[15:0]};
      end
      SZ_W: begin
        fill = sx & sh[31];
        lo   = {{(BEAT_W-32){fill}}, sh[31:0]};
      end
      default: begin
        fill = sx & sh[BEAT_W-1];
        lo   = sh;
      end
    endcase
    return {{BEAT_W{fill}}, lo};
  endfunction

endpackage

// File: rtl/lsu128_decode.sv
module lsu128_decode
  import lsu128_pkg::*;
(
  input  logic [3:0] op,
  input  logic [1:0] mode,
  output op_attr_t   attr
);

  logic need_128;
  logic need_64;
  logic wide_mode;

  assign wide_mode = (mode == MODE_64) || (mode == MODE_128);

  always_comb begin
    attr     = '{legal: 1'b1, store: 1'b0, sext: 1'b0, size: SZ_D};
    need_128 = 1'b0;
    need_64  = 1'b0;
    case (op)
      OP_LB:  begin attr.size = SZ_B; attr.sext = 1'b1; end
      OP_LH:  begin attr.size = SZ_H; attr.sext = 1'b1; end
      OP_LW:  begin attr.size = SZ_W; attr.sext = 1'b1; end
      OP_LD:  begin attr.size = SZ_D; attr.sext = 1'b1; need_64 = 1'b1; end
      OP_LQ:  begin attr.size = SZ_Q; need_128 = 1'b1; end
      OP_LBU: attr.size = SZ_B;
      OP_LHU: attr.size = SZ_H;
      OP_LWU: begin attr.size = SZ_W; need_64 = 1'b1; end
      OP_LDU: begin attr.size = SZ_D; need_128 = 1'b1; end
      OP_SB:  begin attr.size = SZ_B; attr.store = 1'b1; end
      OP_SH:  begin attr.size = SZ_H; attr.store = 1'b1; end
      OP_SW:  begin attr.size = SZ_W; attr.store = 1'b1; end
      OP_SD:  begin attr.size = SZ_D; attr.store = 1'b1; need_64 = 1'b1; end
      OP_SQ:  begin attr.size = SZ_Q; attr.store = 1'b1; need_128 = 1'b1; end
      default: attr.legal = 1'b0;
    endcase
    if (need_128 && (mode != MODE_128)) attr.legal = 1'b0;
    if (need_64 && !wide_mode)          attr.legal = 1'b0;
  end

endmodule

// File: rtl/lsu128_agen.sv
module lsu128_agen #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 12,
  parameter int STEP   = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] ea_held,
  input  logic              second,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] beat_addr
);

  localparam int EXT_W = ADDR_W - IMM_W;

  function automatic logic [ADDR_W-1:0] offset_addr(logic [ADDR_W-1:0] b,
                                                    logic [IMM_W-1:0] i);
    return b + {{EXT_W{i[IMM_W-1]}}, i};
  endfunction

  assign ea        = offset_addr(base, imm);
  assign beat_addr = second ? ea_held + ADDR_W'(STEP) : ea_held;

endmodule

// File: rtl/lsu128_lane.sv
module lsu128_lane
  import lsu128_pkg::*;
(
  input  logic [LANE_W-1:0]     off,
  input  acc_size_e             size,
  input  logic                  sext,
  input  logic                  second,
  input  logic [REG_W-1:0]      st_data,
  input  logic [BEAT_W-1:0]     rdata,
  input  logic [BEAT_W-1:0]     lo_held,
  output logic [BEAT_BYTES-1:0] be,
  output logic [BEAT_W-1:0]     wdata,
  output logic [REG_W-1:0]      ld_value
);

  logic quad;
  assign quad = (size == SZ_Q);

  always_comb begin
    if (quad) begin
      be       = '1;
      wdata    = second ? st_data[REG_W-1:BEAT_W] : st_data[BEAT_W-1:0];
      ld_value = {rdata, lo_held};
    end else begin
      be       = lane_strobe(size, off);
      wdata    = lane_place(st_data[BEAT_W-1:0], off);
      ld_value = widen_load(rdata, off, size, sext);
    end
  end

endmodule

// File: rtl/lsu128_ctrl.sv
module lsu128_ctrl
  import lsu128_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic legal,
  input  logic quad,
  input  logic store,
  input  logic mem_ready,
  output logic req_ready,
  output logic mem_valid,
  output logic second,
  output logic accept_ok,
  output logic capture_lo,
  output logic final_load,
  output logic illegal
);

  beat_state_e state_q;
  beat_state_e state_d;
  logic        accept;
  logic        fire;
  logic        last_beat;

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_valid  = (state_q != ST_IDLE);
  assign second     = (state_q == ST_HI);
  assign accept     = req_valid && req_ready;
  assign accept_ok  = accept && legal;
  assign fire       = mem_valid && mem_ready;
  assign last_beat  = fire && (second || !quad);
  assign capture_lo = fire && !second && quad && !store;
  assign final_load = last_beat && !store;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept_ok) state_d = ST_LO;
      ST_LO:   if (fire) state_d = quad ? ST_HI : ST_IDLE;
      ST_HI:   if (fire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      illegal <= 1'b0;
    end else begin
      state_q <= state_d;
      illegal <= accept && !legal;
    end
  end

endmodule

// File: rtl/lsu128_unit.sv
module lsu128_unit
  import lsu128_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 12,
  parameter int RD_W   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [3:0]            req_op,
  input  logic [1:0]            req_mode,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [IMM_W-1:0]      req_imm,
  input  logic [RD_W-1:0]       req_rd,
  input  logic [REG_W-1:0]      req_wdata,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_we,
  output logic [BEAT_BYTES-1:0] mem_be,
  output logic [BEAT_W-1:0]     mem_wdata,
  input  logic [BEAT_W-1:0]     mem_rdata,
  output logic                  wb_en,
  output logic [RD_W-1:0]       wb_rd,
  output logic [REG_W-1:0]      wb_data,
  output logic                  illegal
);

  op_attr_t          dec_attr;
  logic [ADDR_W-1:0] ea_now;
  logic [ADDR_W-1:0] ea_q;
  acc_size_e         size_q;
  logic              sext_q;
  logic              store_q;
  logic [RD_W-1:0]   rd_q;
  logic [REG_W-1:0]  wdata_q;
  logic [BEAT_W-1:0] lo_q;
  logic              quad_q;

  // internal events, named for the checker
  logic              accept_ok;
  logic              capture_lo;
  logic              final_load;
  logic              hi_beat;
  logic [REG_W-1:0]  ld_value;

  logic              wb_en_q;
  logic [RD_W-1:0]   wb_rd_q;
  logic [REG_W-1:0]  wb_data_q;

  assign quad_q = (size_q == SZ_Q);

  lsu128_decode u_dec (
    .op   (req_op),
    .mode (req_mode),
    .attr (dec_attr)
  );

  lsu128_agen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .STEP   (BEAT_BYTES)
  ) u_agen (
    .base      (req_base),
    .imm       (req_imm),
    .ea_held   (ea_q),
    .second    (hi_beat),
    .ea        (ea_now),
    .beat_addr (mem_addr)
  );

  lsu128_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .legal      (dec_attr.legal),
    .quad       (quad_q),
    .store      (store_q),
    .mem_ready  (mem_ready),
    .req_ready  (req_ready),
    .mem_valid  (mem_valid),
    .second     (hi_beat),
    .accept_ok  (accept_ok),
    .capture_lo (capture_lo),
    .final_load (final_load),
    .illegal    (illegal)
  );

  lsu128_lane u_lane (
    .off      (ea_q[LANE_W-1:0]),
    .size     (size_q),
    .sext     (sext_q),
    .second   (hi_beat),
    .st_data  (wdata_q),
    .rdata    (mem_rdata),
    .lo_held  (lo_q),
    .be       (mem_be),
    .wdata    (mem_wdata),
    .ld_value (ld_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q    <= '0;
      size_q  <= SZ_D;
      sext_q  <= 1'b0;
      store_q <= 1'b0;
      rd_q    <= '0;
      wdata_q <= '0;
    end else if (accept_ok) begin
      ea_q    <= ea_now;
      size_q  <= dec_attr.size;
      sext_q  <= dec_attr.sext;
      store_q <= dec_attr.store;
      rd_q    <= req_rd;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (capture_lo) begin
      lo_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en_q   <= 1'b0;
      wb_rd_q   <= '0;
      wb_data_q <= '0;
    end else begin
      wb_en_q <= final_load && (rd_q != '0);
      if (final_load) begin
        wb_rd_q   <= rd_q;
        wb_data_q <= ld_value;
      end
    end
  end

  assign mem_we  = store_q;
  assign wb_en   = wb_en_q;
  assign wb_rd   = wb_rd_q;
  assign wb_data = wb_data_q;

endmodule

// File: rtl/lsu128_check.sv
module lsu128_check #(
  parameter int ADDR_W = 64,
  parameter int RD_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [7:0]        mem_be,
  input logic [63:0]       mem_wdata,
  input logic              wb_en,
  input logic [RD_W-1:0]   wb_rd,
  input logic              illegal,
  input logic              hi_beat
);

  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_be) && $stable(mem_wdata)));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  assert_upper_beat_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_beat) |-> (mem_addr == $past(mem_addr) + ADDR_W'(8)));

  assert_upper_beat_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_beat |-> (mem_be == 8'hFF));

  assert_no_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_rd != '0));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);

  assert_refused_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_valid && !wb_en));

endmodule

bind lsu128_unit lsu128_check #(
  .ADDR_W (ADDR_W),
  .RD_W   (RD_W)
) u_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .wb_en     (wb_en),
  .wb_rd     (wb_rd),
  .illegal   (illegal),
  .hi_beat   (hi_beat)
);

// File: tb/lsu128_unit_test.sv
module lsu128_unit_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_op = '0;
  logic [1:0]   req_mode = '0;
  logic [63:0]  req_base = '0;
  logic [11:0]  req_imm = '0;
  logic [4:0]   req_rd = '0;
  logic [127:0] req_wdata = '0;
  logic         mem_valid;
  logic         mem_ready = 1'b1;
  logic [63:0]  mem_addr;
  logic         mem_we;
  logic [7:0]   mem_be;
  logic [63:0]  mem_wdata;
  logic [63:0]  mem_rdata;
  logic         wb_en;
  logic [4:0]   wb_rd;
  logic [127:0] wb_data;
  logic         illegal;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int beats_seen = 0;
  int wb_seen    = 0;
  int ill_seen   = 0;

  logic [63:0] q_addr [$];
  logic        q_we   [$];
  logic [7:0]  q_be   [$];
  logic [63:0] q_wd   [$];
  string       q_tag  [$];
  bit           exp_wb_pending  = 0;
  logic [4:0]   exp_wb_rd       = '0;
  logic [127:0] exp_wb_data     = '0;
  string        exp_wb_tag      = "";
  bit           exp_ill_pending = 0;

  logic [63:0] mem_arr [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu128_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mode(req_mode), .req_base(req_base), .req_imm(req_imm),
    .req_rd(req_rd), .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data),
    .illegal(illegal)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] init_word(int idx);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = 8'((idx * 8 + b) * 37 + 145);
    return w;
  endfunction

  function automatic logic [7:0] get_byte(logic [63:0] a);
    return mem_arr[a[9:3]][{a[2:0], 3'b000} +: 8];
  endfunction

  // memory model: combinational read, byte-masked write on handshake
  assign mem_rdata = mem_arr[mem_addr[9:3]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem_arr[i] <= init_word(i);
    end else if (mem_valid && mem_ready && mem_we) begin
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) mem_arr[mem_addr[9:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  // ready pattern and per-cycle comparison with the reference queues
  always @(negedge clk) begin
    logic [63:0] ea_e, wd_e, msk;
    logic        we_e;
    logic [7:0]  be_e;
    string       tg;
    cyc++;
    mem_ready = ((cyc % 4) != 2) && ((cyc % 7) != 3);
    if (rst_n) begin
      if (mem_valid) chk(!req_ready, "R8", "req_ready low while beat pending", 128'(req_ready), 128'd0);
      if (mem_valid && mem_ready) begin
        beats_seen++;
        if (q_addr.size() == 0) begin
          chk(1'b0, "R2", "unexpected memory beat", 128'(mem_addr), 128'd0);
        end else begin
          ea_e = q_addr.pop_front();
          we_e = q_we.pop_front();
          be_e = q_be.pop_front();
          wd_e = q_wd.pop_front();
          tg   = q_tag.pop_front();
          chk(mem_addr == ea_e, tg, "beat address", 128'(mem_addr), 128'(ea_e));
          chk(mem_we == we_e, tg, "beat direction", 128'(mem_we), 128'(we_e));
          chk(mem_be == be_e, tg, "beat strobes", 128'(mem_be), 128'(be_e));
          if (we_e) begin
            for (int b = 0; b < 8; b++) msk[8*b +: 8] = {8{be_e[b]}};
            chk((mem_wdata & msk) == (wd_e & msk), tg, "beat write data",
                128'(mem_wdata & msk), 128'(wd_e & msk));
          end
        end
      end
      if (wb_en) begin
        wb_seen++;
        chk(exp_wb_pending, "R9", "write-back expected", 128'(wb_en), 128'(exp_wb_pending));
        if (exp_wb_pending) begin
          chk(wb_rd == exp_wb_rd, exp_wb_tag, "write-back register", 128'(wb_rd), 128'(exp_wb_rd));
          chk(wb_data == exp_wb_data, exp_wb_tag, "write-back data", wb_data, exp_wb_data);
          exp_wb_pending = 0;
        end
      end
      if (illegal) begin
        ill_seen++;
        chk(exp_ill_pending, "R7", "illegal flag expected", 128'(illegal), 128'(exp_ill_pending));
        exp_ill_pending = 0;
      end
    end
  end

  task automatic push_beat(input logic [63:0] a, input logic we, input logic [7:0] be,
                           input logic [63:0] wd, input string tag);
    q_addr.push_back(a);
    q_we.push_back(we);
    q_be.push_back(be);
    q_wd.push_back(wd);
    q_tag.push_back(tag);
  endtask

  task automatic run_op(input logic [3:0] op, input logic [1:0] mode, input logic [63:0] base,
                        input logic [11:0] imm, input logic [4:0] rd, input logic [127:0] wd,
                        input string tag);
    logic [63:0]  ea;
    logic [63:0]  w;
    logic [127:0] v;
    logic [7:0]   be;
    int  n, nbeats, nwb, b0, w0, i0;
    bit  st, sx, ok, wide, full;
    ea   = base + {{52{imm[11]}}, imm};
    wide = (mode == 2'b10) || (mode == 2'b11);
    full = (mode == 2'b11);
    ok = 1; st = 0; sx = 0; n = 8;
    case (op)
      4'd0:  begin n = 1;  sx = 1; end
      4'd1:  begin n = 2;  sx = 1; end
      4'd2:  begin n = 4;  sx = 1; end
      4'd3:  begin n = 8;  sx = 1; ok = wide; end
      4'd4:  begin n = 16; ok = full; end
      4'd5:  n = 1;
      4'd6:  n = 2;
      4'd7:  begin n = 4;  ok = wide; end
      4'd8:  begin n = 8;  ok = full; end
      4'd9:  begin n = 1;  st = 1; end
      4'd10: begin n = 2;  st = 1; end
      4'd11: begin n = 4;  st = 1; end
      4'd12: begin n = 8;  st = 1; ok = wide; end
      4'd13: begin n = 16; st = 1; ok = full; end
      default: ok = 0;
    endcase
    nbeats = 0;
    nwb    = 0;
    if (!ok) begin
      exp_ill_pending = 1;
    end else begin
      if (n == 16) begin
        push_beat(ea, st, 8'hFF, wd[63:0], tag);
        push_beat(ea + 64'd8, st, 8'hFF, wd[127:64], tag);
        nbeats = 2;
      end else begin
        be = 8'((1 << n) - 1) << ea[2:0];
        w  = '0;
        for (int i = 0; i < n; i++) w[8*(int'(ea[2:0]) + i) +: 8] = wd[8*i +: 8];
        push_beat(ea, st, be, w, tag);
        nbeats = 1;
      end
      if (!st) begin
        v = '0;
        for (int i = 0; i < n; i++) v[8*i +: 8] = get_byte(ea + 64'(i));
        if (sx && v[8*n-1]) for (int j = 8*n; j < 128; j++) v[j] = 1'b1;
        if (rd != 5'd0) begin
          exp_wb_pending = 1;
          exp_wb_rd      = rd;
          exp_wb_data    = v;
          exp_wb_tag     = tag;
          nwb            = 1;
        end
      end
    end
    b0 = beats_seen;
    w0 = wb_seen;
    i0 = ill_seen;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_mode  = mode;
    req_base  = base;
    req_imm   = imm;
    req_rd    = rd;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 40; t++) begin
      if (q_addr.size() == 0 && !exp_wb_pending && !exp_ill_pending) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(q_addr.size() == 0 && !exp_wb_pending && !exp_ill_pending, tag, "operation completed",
        128'(q_addr.size()), 128'd0);
    chk(beats_seen - b0 == nbeats, tag, "beat count", 128'(beats_seen - b0), 128'(nbeats));
    chk(wb_seen - w0 == nwb, tag, "write-back count", 128'(wb_seen - w0), 128'(nwb));
    chk(ill_seen - i0 == int'(!ok), tag, "illegal count", 128'(ill_seen - i0), 128'(!ok));
    q_addr.delete(); q_we.delete(); q_be.delete(); q_wd.delete(); q_tag.delete();
    exp_wb_pending  = 0;
    exp_ill_pending = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 128'd0, 128'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] qd;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset req_ready", 128'(req_ready), 128'd1);
    chk(mem_valid == 1'b0, "R10", "reset mem_valid", 128'(mem_valid), 128'd0);
    chk(wb_en == 1'b0, "R10", "reset wb_en", 128'(wb_en), 128'd0);
    chk(illegal == 1'b0, "R10", "reset illegal", 128'(illegal), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: sub-quad loads, signed and unsigned, at several lane offsets
    run_op(4'd3, 2'b11, 64'h100, 12'h008, 5'd5,  '0, "R3");
    run_op(4'd0, 2'b01, 64'h200, 12'h003, 5'd6,  '0, "R2");
    run_op(4'd5, 2'b01, 64'h200, 12'h003, 5'd6,  '0, "R3");
    run_op(4'd0, 2'b11, 64'h200, 12'h005, 5'd9,  '0, "R3");
    run_op(4'd1, 2'b10, 64'h040, 12'h006, 5'd7,  '0, "R2");
    run_op(4'd6, 2'b10, 64'h040, 12'h006, 5'd7,  '0, "R3");
    run_op(4'd2, 2'b01, 64'h300, 12'h004, 5'd8,  '0, "R2");
    run_op(4'd7, 2'b10, 64'h300, 12'h004, 5'd8,  '0, "R3");
    run_op(4'd8, 2'b11, 64'h3F8, 12'h000, 5'd10, '0, "R3");
    run_op(4'd3, 2'b10, 64'h3F8, 12'h000, 5'd31, '0, "R3");

    // R1: address wrap and negative offsets
    run_op(4'd3, 2'b11, 64'hFFFF_FFFF_FFFF_FF00, 12'h110, 5'd11, '0, "R1");
    run_op(4'd2, 2'b01, 64'h180, 12'hFF8, 5'd12, '0, "R1");
    run_op(4'd1, 2'b11, 64'h000, 12'h7FE, 5'd13, '0, "R1");

    // R4: quad load
    run_op(4'd4, 2'b11, 64'h080, 12'h010, 5'd14, '0, "R4");
    run_op(4'd4, 2'b11, 64'h3E0, 12'hFF0, 5'd15, '0, "R4");

    // R6: narrow stores, then read back the doubleword
    run_op(4'd9,  2'b01, 64'h208, 12'h005, 5'd0, 128'hA5, "R6");
    run_op(4'd10, 2'b01, 64'h208, 12'h002, 5'd0, 128'hFFFF_BEEF, "R6");
    run_op(4'd11, 2'b10, 64'h208, 12'h004, 5'd0, 128'h1234_5678_8765_4321, "R6");
    run_op(4'd12, 2'b11, 64'h210, 12'h000, 5'd0, 128'h0F1E_2D3C_4B5A_6978, "R6");
    run_op(4'd8,  2'b11, 64'h208, 12'h000, 5'd16, '0, "R6");

    // R5: quad store then quad load back
    qd = 128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF;
    run_op(4'd13, 2'b11, 64'h240, 12'h000, 5'd0, qd, "R5");
    chk(mem_arr[72] == qd[63:0], "R5", "low half at ea", 128'(mem_arr[72]), 128'(qd[63:0]));
    chk(mem_arr[73] == qd[127:64], "R5", "high half at ea+8", 128'(mem_arr[73]), 128'(qd[127:64]));
    run_op(4'd4, 2'b11, 64'h240, 12'h000, 5'd17, '0, "R5");

    // R7: mode legality
    run_op(4'd4,  2'b10, 64'h080, 12'h000, 5'd3, '0, "R7");
    run_op(4'd8,  2'b10, 64'h080, 12'h000, 5'd3, '0, "R7");
    run_op(4'd13, 2'b10, 64'h080, 12'h000, 5'd3, qd, "R7");
    run_op(4'd3,  2'b01, 64'h080, 12'h000, 5'd3, '0, "R7");
    run_op(4'd7,  2'b00, 64'h080, 12'h000, 5'd3, '0, "R7");
    run_op(4'd12, 2'b01, 64'h080, 12'h000, 5'd3, qd, "R7");
    run_op(4'd14, 2'b11, 64'h080, 12'h000, 5'd3, '0, "R7");
    run_op(4'd15, 2'b11, 64'h080, 12'h000, 5'd3, '0, "R7");
    run_op(4'd12, 2'b10, 64'h0C0, 12'h000, 5'd0, qd, "R7");
    run_op(4'd7,  2'b11, 64'h0C0, 12'h004, 5'd3, '0, "R7");

    // R9: load to register zero still makes beats but no write-back
    run_op(4'd3, 2'b11, 64'h100, 12'h000, 5'd0, '0, "R9");
    run_op(4'd4, 2'b11, 64'h100, 12'h000, 5'd0, '0, "R9");
    run_op(4'd5, 2'b11, 64'h101, 12'h000, 5'd1, '0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule